// File: doc/BRIEF.md
# Serial Flash Status and Write-Permission Controller

This block is the status register and write-permission logic of a serial flash memory. It sits behind a command decoder that has already turned the serial stream into requests. Each request carries a kind code, a target address and a data byte. The block keeps a busy flag, a write-enable latch, a two-bit protection-size field and a protection-lock bit. For each request it decides whether the request may proceed. For accepted requests it updates a small byte array that stands in for the flash cells.

Permission depends on four things: the write-enable latch, the protection-size field, the lock bit, and the level of the active-low write-protect pin. A refused request is dropped silently and raises no error. An accepted write holds the busy flag high for a fixed number of cycles, set by a parameter. While busy is high, the only thing the block offers is the status byte, which is always present on its output so that a master can poll it. When the busy period ends, the write-enable latch clears by itself.

The protection-size field selects how much of the array is guarded, measured from the top of the address space. Sector erase works on sectors whose size is a power of two set by a parameter. Byte program can only clear bits.

Top module: `flash_wprot`

## Requirements
- R1: After reset the status byte reads 0x0C. The field layout is: bit 0 busy, bit 1 write-enable latch, bit 2 protect-size low bit, bit 3 protect-size high bit, bit 7 lock, and bits 4 to 6 always 0. Every array byte reads FFh after reset.
- R2: Request kind 0 (enable) sets bit 1 of the status byte, and kind 1 (disable) clears it. Neither of them starts a busy period.
- R3: A status write (kind 2), byte program (kind 3), sector erase (kind 4) or chip erase (kind 5) issued while the write-enable latch is 0 is ignored. No busy period starts and no state changes.
- R4: A status write is accepted when the write-protect pin is high or the lock bit is 0. It loads protect-size bits 1:0 from data bits 3:2 and the lock bit from data bit 7. When the pin is low and the lock bit is 1, the status write is ignored and the write-enable latch keeps its value.
- R5: The protect-size value determines which addresses are guarded: 00 guards none, 01 guards addresses whose top two bits are 11, 10 guards addresses whose top bit is 1, and 11 guards all. A program or sector erase whose address is guarded is ignored, and the write-enable latch keeps its value.
- R6: A chip erase is accepted only when protect-size is 00. It then sets every array byte to FFh.
- R7: An accepted byte program replaces the target byte with the bitwise AND of the old byte and the data.
- R8: An accepted sector erase sets to FFh every byte whose address bits above the sector offset match the request address. All other bytes stay unchanged.
- R9: An accepted write holds status bit 0 high for exactly BUSY_CYCLES cycles, starting in the cycle after acceptance. The write-enable latch stays 1 during that period and reads 0 once busy falls.
- R10: While busy is high, every request, including enable and disable, is ignored. The status byte stays readable throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A decoded request is present this cycle |
| reqKind | input | 3 | Request kind: 0 enable, 1 disable, 2 status write, 3 program, 4 sector erase, 5 chip erase |
| reqAddr | input | ADDR_W | Target byte address |
| reqData | input | 8 | Program data or new status value |
| wpN | input | 1 | Write-protect pin level; low allows the lock bit to take effect |
| rdAddr | input | ADDR_W | Array read address |
| status | output | 8 | Status byte |
| rdData | output | 8 | Array byte at rdAddr |

## Verification
Directed sequences step through each protection size with requests aimed just inside and just outside the guarded region. This separates an off-by-one region decode from a correct one. Status writes are issued under all four combinations of pin level and lock bit, which separates the joint lock rule from a rule that looks at only one of the two. Requests are also injected in the first busy cycle; these show whether the busy gate covers enable and disable as well as array writes. Random requests with random pin levels and addresses then build up program, erase and lock histories. After every request, a bench model compares the whole array and the status byte against the design.

// File: rtl/flash_wprot_pkg.sv
package flash_wprot_pkg;

  typedef enum logic [2:0] {
    KIND_WREN   = 3'd0,
    KIND_WRDI   = 3'd1,
    KIND_WRSR   = 3'd2,
    KIND_PROG   = 3'd3,
    KIND_SERASE = 3'd4,
    KIND_CERASE = 3'd5
  } reqKind_e;

  typedef struct packed {
    logic prog;
    logic sector;
    logic chip;
  } memStrobe_t;

  // Guarded-region decode from the top two address bits.
  function automatic logic isGuarded(input logic [1:0] size, input logic [1:0] top2);
    case (size)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl
  import flash_wprot_pkg::*;
#(
  parameter int BUSY_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic [1:0] addrTop,
  input  logic [1:0] newSize,
  input  logic       newLock,
  input  logic       wpN,
  output memStrobe_t strobe,
  output logic [7:0] status
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic             busy;
  logic             wel;
  logic             lockBit;
  logic [1:0]       sizeBits;
  logic [CNT_W-1:0] cnt;

  logic idleReq, guarded, srOpen;
  logic acceptSr, acceptProg, acceptSec, acceptChip, acceptAny;

  assign idleReq    = reqValid && !busy;
  assign guarded    = isGuarded(sizeBits, addrTop);
  assign srOpen     = wpN || !lockBit;
  assign acceptSr   = idleReq && wel && (reqKind == KIND_WRSR) && srOpen;
  assign acceptProg = idleReq && wel && (reqKind == KIND_PROG) && !guarded;
  assign acceptSec  = idleReq && wel && (reqKind == KIND_SERASE) && !guarded;
  assign acceptChip = idleReq && wel && (reqKind == KIND_CERASE) && (sizeBits == 2'b00);
  assign acceptAny  = acceptSr || acceptProg || acceptSec || acceptChip;

  always_comb begin
    strobe.prog   = acceptProg;
    strobe.sector = acceptSec;
    strobe.chip   = acceptChip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      wel      <= 1'b0;
      lockBit  <= 1'b0;
      sizeBits <= 2'b11;
      cnt      <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (acceptAny) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(BUSY_CYCLES - 1);
      if (acceptSr) begin
        sizeBits <= newSize;
        lockBit  <= newLock;
      end
    end else if (idleReq && reqKind == KIND_WREN) begin
      wel <= 1'b1;
    end else if (idleReq && reqKind == KIND_WRDI) begin
      wel <= 1'b0;
    end
  end

  assign status = {lockBit, 3'b000, sizeBits, wel, busy};

endmodule

// File: rtl/flash_wprot_dp.sv
module flash_wprot_dp
  import flash_wprot_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SECTOR_AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    logic inSector;
    assign inSector = (wrAddr[ADDR_W-1:SECTOR_AW] == MY_ADDR[ADDR_W-1:SECTOR_AW]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cells[g] <= 8'hFF;
      else if (strobe.chip || (strobe.sector && inSector))
        cells[g] <= 8'hFF;
      else if (strobe.prog && wrAddr == MY_ADDR)
        cells[g] <= cells[g] & wrData;
    end
  end

  assign rdData = cells[rdAddr];

endmodule

// File: rtl/flash_wprot.sv
module flash_wprot
  import flash_wprot_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SECTOR_AW   = 9,
  parameter int BUSY_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        status,
  output logic [7:0]        rdData
);
  memStrobe_t strobe;

  flash_wprot_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .addrTop  (reqAddr[ADDR_W-1 -: 2]),
    .newSize  (reqData[3:2]),
    .newLock  (reqData[7]),
    .wpN      (wpN),
    .strobe   (strobe),
    .status   (status)
  );

  flash_wprot_dp #(.ADDR_W(ADDR_W), .SECTOR_AW(SECTOR_AW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (reqAddr),
    .wrData (reqData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

endmodule

// File: rtl/flash_wprot_chk.sv
module flash_wprot_chk #(
  parameter int BUSY_CYCLES = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic       wpN,
  input logic [7:0] status
);
  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busyRun <= 0;
    else if (status[0]) busyRun <= busyRun + 1;
    else                busyRun <= 0;
  end

  // R3
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> $past(status[1]));

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status[7] && !wpN) |=> $stable(status[7:2]));

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[0] |-> (busyRun < BUSY_CYCLES));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[0]) |-> (!status[1] && busyRun == BUSY_CYCLES));

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[0] |=> $stable(status[7:2]));

endmodule

bind flash_wprot flash_wprot_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wpN    (wpN),
  .status (status)
);

// File: tb/flash_wprot_bench.sv
module flash_wprot_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 11;
  localparam int SECTOR_AW   = 9;
  localparam int BUSY_CYCLES = 6;
  localparam int DEPTH       = 1 << ADDR_W;

  localparam logic [2:0] K_WREN = 3'd0, K_WRDI = 3'd1, K_WRSR = 3'd2,
                         K_PROG = 3'd3, K_SERASE = 3'd4, K_CERASE = 3'd5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [2:0]        reqKind = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0]        reqData = '0;
  logic              wpN = 1'b1;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        status;
  logic [7:0]        rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mMem [DEPTH];
  logic [1:0] mSize;
  logic       mLock;
  logic       mWel;

  flash_wprot #(.ADDR_W(ADDR_W), .SECTOR_AW(SECTOR_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_flash_wprot (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqData(reqData), .wpN(wpN), .rdAddr(rdAddr), .status(status), .rdData(rdData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic guardedAt(input logic [1:0] size, input logic [ADDR_W-1:0] a);
    logic [1:0] t;
    t = a[ADDR_W-1 -: 2];
    if (size == 2'b00) return 1'b0;
    if (size == 2'b01) return t == 2'b11;
    if (size == 2'b10) return t[1];
    return 1'b1;
  endfunction

  function automatic logic [7:0] expStatus(input logic b, input logic w);
    return {mLock, 3'b000, mSize, w, b};
  endfunction

  task automatic checkEq(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkArray(input string tag);
    int bad = 0;
    int firstA = -1;
    logic [7:0] actV = '0, expV = '0;
    for (int a = 0; a < DEPTH; a++) begin
      rdAddr = ADDR_W'(a);
      #1;
      if (rdData !== mMem[a]) begin
        if (bad == 0) begin firstA = a; actV = rdData; expV = mMem[a]; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s array at %0h: actual %h expected %h (%0d bytes differ)",
               tag, firstA, actV, expV, bad);
    end
  endtask

  task automatic modelApply(input logic [2:0] k, input logic [ADDR_W-1:0] a,
                            input logic [7:0] d, output bit acc);
    acc = 0;
    case (k)
      K_WREN: mWel = 1'b1;
      K_WRDI: mWel = 1'b0;
      K_WRSR: if (mWel && (wpN || !mLock)) begin
        mSize = d[3:2]; mLock = d[7]; acc = 1;
      end
      K_PROG: if (mWel && !guardedAt(mSize, a)) begin
        mMem[a] = mMem[a] & d; acc = 1;
      end
      K_SERASE: if (mWel && !guardedAt(mSize, a)) begin
        for (int i = 0; i < DEPTH; i++)
          if ((i >> SECTOR_AW) == (int'(a) >> SECTOR_AW)) mMem[i] = 8'hFF;
        acc = 1;
      end
      K_CERASE: if (mWel && mSize == 2'b00) begin
        for (int i = 0; i < DEPTH; i++) mMem[i] = 8'hFF;
        acc = 1;
      end
      default: ;
    endcase
  endtask

  task automatic doOp(input logic [2:0] k, input logic [ADDR_W-1:0] a, input logic [7:0] d,
                      input bit inj, input logic [2:0] injKind, input string tag);
    bit acc;
    modelApply(k, a, d, acc);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (acc) begin
      checkEq(status, expStatus(1'b1, 1'b1), {tag, " R9 busy start"});
      for (int i = 1; i <= BUSY_CYCLES; i++) begin
        if (i == 1 && inj) begin
          reqValid = 1'b1; reqKind = injKind; reqAddr = a; reqData = 8'h00;
        end
        @(negedge clk);
        reqValid = 1'b0;
        if (i + 1 == BUSY_CYCLES) checkEq({7'b0, status[0]}, 8'h01, {tag, " R9 busy held"});
      end
      mWel = 1'b0;
      checkEq(status, expStatus(1'b0, 1'b0), {tag, " R9 R10 end of busy"});
    end else begin
      checkEq(status, expStatus(1'b0, mWel), {tag, " ignored or latch op"});
    end
    checkArray(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mMem[i] = 8'hFF;
    mSize = 2'b11; mLock = 1'b0; mWel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkEq(status, 8'h0C, "R1 reset status");
    checkArray("R1 reset array");

    // R3 program without latch
    doOp(K_PROG, 11'h005, 8'h00, 0, K_WREN, "R3 prog no latch");
    // R2 enable and disable
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_WRDI, '0, '0, 0, K_WREN, "R2 disable");
    doOp(K_WRSR, '0, 8'h00, 0, K_WREN, "R3 status write no latch");
    // R4 open status write
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_WRSR, '0, 8'h00, 0, K_WREN, "R4 clear protection");
    // R7 program AND behaviour
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_PROG, 11'h005, 8'hA5, 0, K_WREN, "R7 first program");
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_PROG, 11'h005, 8'h3C, 0, K_WREN, "R7 second program AND");
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_PROG, 11'h7FF, 8'h11, 0, K_WREN, "R5 size 00 top byte");
    // R4 lock with pin low while lock bit 0
    wpN = 1'b0;
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_WRSR, '0, 8'h84, 0, K_WREN, "R4 set quarter and lock");
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_WRSR, '0, 8'h00, 0, K_WREN, "R4 locked write ignored");
    // R5 quarter region edges
    doOp(K_PROG, 11'h600, 8'h00, 0, K_WREN, "R5 quarter guarded");
    doOp(K_PROG, 11'h5FF, 8'h0F, 0, K_WREN, "R5 just below quarter");
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_SERASE, 11'h700, '0, 0, K_WREN, "R5 sector erase guarded");
    doOp(K_CERASE, '0, '0, 0, K_WREN, "R6 chip erase refused");
    doOp(K_WRDI, '0, '0, 0, K_WREN, "R2 disable");
    // R4 pin high releases lock
    wpN = 1'b1;
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_WRSR, '0, 8'h08, 0, K_WREN, "R4 pin high unlock");
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_PROG, 11'h400, 8'h00, 0, K_WREN, "R5 half guarded");
    doOp(K_PROG, 11'h3FF, 8'h5A, 0, K_WREN, "R5 just below half");
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_WRSR, '0, 8'h00, 0, K_WREN, "R4 clear protection");
    // R8 sector erase touches one sector only
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_SERASE, 11'h005, '0, 0, K_WREN, "R8 sector erase");
    // R10 request injected during busy
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_PROG, 11'h100, 8'h00, 1, K_WREN, "R10 enable during busy");
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_PROG, 11'h101, 8'hF0, 1, K_PROG, "R10 program during busy");
    // R6 chip erase allowed
    doOp(K_WREN, '0, '0, 0, K_WREN, "R2 enable");
    doOp(K_CERASE, '0, '0, 1, K_WRDI, "R6 chip erase");

    // random mix
    for (int n = 0; n < 120; n++) begin
      logic [2:0] k;
      logic [2:0] ik;
      wpN = 1'($urandom % 2);
      if ($urandom % 3 != 0) doOp(K_WREN, '0, '0, 0, K_WREN, "R2 random enable");
      k  = 3'($urandom % 6);
      ik = 3'($urandom % 6);
      doOp(k, ADDR_W'($urandom), 8'($urandom), 1'($urandom % 2), ik, "R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule